// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block holds two down-counting interval timers behind a small synchronous register port. Each channel keeps a reload value, a live count and a control word. The control word turns the channel on or off. It picks single-shot or auto-reload operation and picks one of four count rates. A shared free-running prescaler supplies those rates as the core clock divided by 1, 2, 4 or 8. When a running channel's count steps from 1 to 0, that step is terminal count, and the channel sets a sticky pending flag. The flag drives that channel's interrupt line as a level until software writes a 1 to the pending bit.

Software addresses the registers as 32-bit words. Within a channel the reload value is at byte offset 0x0, the count at 0x4 and the control word at 0x8. Channel 1 starts at byte offset 0x10, and offset 0xC reads as zero. The port carries the word address, which is byte address bits 4:2. Reads are combinational from the address.

Each channel runs a two-state machine. **ST_IDLE** means not counting. **ST_RUN** means the channel steps on every selected prescaler tick. There are three transitions:
- **arm**: ST_IDLE to ST_RUN, on a control write with the enable bit set.
- **disarm**: ST_RUN to ST_IDLE, on a control write with the enable bit clear.
- **expire**: ST_RUN to ST_IDLE, at terminal count in single-shot mode, unless a control write in the same cycle sets the enable bit.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register of both channels reads 0, both channels are in ST_IDLE and both interrupt lines are low.
- R2: The reload register reads back the value written. The control word reads back as bit 0 enable (1 means ST_RUN), bit 1 auto-reload, bits 3:2 rate select and bit 4 pending. Other bits read 0, and offset 0xC reads 0.
- R3: In ST_RUN with rate select 0 the count drops by one on every clock edge. A channel in ST_IDLE holds its count.
- R4: Rate select values 1, 2 and 3 step the count once every 2, 4 and 8 clock edges, measured over any window of 64 edges.
- R5: In single-shot mode (bit 1 = 0), terminal count leaves the count at 0, takes the expire transition so the enable bit reads 0, and sets pending.
- R6: In auto-reload mode (bit 1 = 1), terminal count loads the reload value into the count in the same edge, sets pending, and the channel stays in ST_RUN.
- R7: The interrupt line equals the pending bit. It stays high until a control write with bit 4 set. A control write with bit 4 clear leaves it high. If terminal count and a clear fall in the same cycle, the set wins.
- R8: A write to the count register loads it directly, even in ST_RUN. The write takes priority over a tick in the same cycle.
- R9: The two channels are independent. Writes to, and terminal counts of, one channel change no register and no interrupt line of the other.
- R10: A channel in ST_RUN whose count is 0 loads its reload value on the next selected tick without setting pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W-2 (3) | Word address, byte address bits 4:2 |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | N_TIMERS (2) | Interrupt level per channel, equal to its pending bit |

## Verification
A register write takes effect at the clock edge that samples the strobe, and read data follows the address in the same cycle. The bench therefore drives each access on a falling edge and reads the result at the next falling edge. At rate 0, a channel armed by a write shows its count unchanged at the first falling edge after the write. It then shows one step less at each later falling edge. Pending and the interrupt rise at the same edge that counts from 1 to 0, or reloads. The bench walks that schedule one falling edge at a time. Slower rates depend on the prescaler phase, so they are checked as a count difference over exactly 64 edges, which does not depend on phase.

// File: rtl/timer_pkg.sv
package timer_pkg;

    // Number of selectable count rates: divide by 1, 2, 4, 8.
    localparam int RATE_NUM = 4;
    localparam int SEL_W    = $clog2(RATE_NUM);

    // Control word layout.
    localparam int CTL_EN      = 0;
    localparam int CTL_AUTO    = 1;
    localparam int CTL_RATE_LO = 2;
    localparam int CTL_RATE_HI = CTL_RATE_LO + SEL_W - 1;
    localparam int CTL_PEND    = CTL_RATE_HI + 1;

    // Register slot within a channel (word address bits 1:0).
    localparam logic [1:0] REG_RELOAD = 2'd0;
    localparam logic [1:0] REG_COUNT  = 2'd1;
    localparam logic [1:0] REG_CTRL   = 2'd2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [RATE_NUM-1:0] tick
);

    localparam int PRE_W = RATE_NUM - 1;

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    assign tick[0] = 1'b1;

    // Rate k pulses once every 2**k cycles.
    for (genvar k = 1; k < RATE_NUM; k++) begin : g_tick
        assign tick[k] = &pre_q[k-1:0];
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RATE_NUM-1:0] tick,
    input  logic                wr_reload,
    input  logic                wr_count,
    input  logic                wr_ctrl,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   reload,
    output logic [DATA_W-1:0]   count,
    output logic                run,
    output logic                autold,
    output logic [SEL_W-1:0]    rate,
    output logic                pend
);

    tmr_state_e        state_q, state_d;
    logic [DATA_W-1:0] reload_q, count_q;
    logic              autold_q, pend_q;
    logic [SEL_W-1:0]  rate_q;
    logic              step, terminal;

    // A counting step happens on the selected tick while running,
    // unless software overwrites the count in the same cycle.
    assign step     = (state_q == ST_RUN) && tick[rate_q] && !wr_count;
    assign terminal = step && (count_q == DATA_W'(1));

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic: arm, disarm, expire.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ctrl && wdata[CTL_EN]) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (wr_ctrl)                     state_d = wdata[CTL_EN] ? ST_RUN : ST_IDLE;
                else if (terminal && !autold_q) state_d = ST_IDLE;
            end
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            count_q  <= '0;
            autold_q <= 1'b0;
            rate_q   <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= wdata;

            if (wr_count) begin
                count_q <= wdata;
            end else if (step) begin
                if (count_q == DATA_W'(1))      count_q <= autold_q ? reload_q : '0;
                else if (count_q == '0)         count_q <= reload_q;
                else                            count_q <= count_q - 1'b1;
            end

            if (wr_ctrl) begin
                autold_q <= wdata[CTL_AUTO];
                rate_q   <= wdata[CTL_RATE_HI:CTL_RATE_LO];
            end

            // A terminal count in the same cycle beats a clear.
            if (terminal)                       pend_q <= 1'b1;
            else if (wr_ctrl && wdata[CTL_PEND]) pend_q <= 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        run    = (state_q == ST_RUN);
        reload = reload_q;
        count  = count_q;
        autold = autold_q;
        rate   = rate_q;
        pend   = pend_q;
    end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import timer_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:2]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [N_TIMERS-1:0] irq
);

    localparam int CH_W = ADDR_W - 4;

    logic [RATE_NUM-1:0]              tick;
    logic [CH_W-1:0]                  ch_sel;
    logic [1:0]                       reg_sel;
    logic [N_TIMERS-1:0][DATA_W-1:0]  ch_reload;
    logic [N_TIMERS-1:0][DATA_W-1:0]  ch_count;
    logic [N_TIMERS-1:0][SEL_W-1:0]   ch_rate;
    logic [N_TIMERS-1:0]              ch_run, ch_auto, ch_pend;

    assign ch_sel  = bus_addr[ADDR_W-1:4];
    assign reg_sel = bus_addr[3:2];

    tmr_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
        logic hit;
        assign hit = bus_wr && (ch_sel == CH_W'(i));

        tmr_channel #(.DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .wr_reload (hit && (reg_sel == REG_RELOAD)),
            .wr_count  (hit && (reg_sel == REG_COUNT)),
            .wr_ctrl   (hit && (reg_sel == REG_CTRL)),
            .wdata     (bus_wdata),
            .reload    (ch_reload[i]),
            .count     (ch_count[i]),
            .run       (ch_run[i]),
            .autold    (ch_auto[i]),
            .rate      (ch_rate[i]),
            .pend      (ch_pend[i])
        );

        assign irq[i] = ch_pend[i];
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (ch_sel == CH_W'(i)) begin
                unique case (reg_sel)
                    REG_RELOAD: bus_rdata = ch_reload[i];
                    REG_COUNT:  bus_rdata = ch_count[i];
                    REG_CTRL: begin
                        bus_rdata[CTL_EN]                  = ch_run[i];
                        bus_rdata[CTL_AUTO]                = ch_auto[i];
                        bus_rdata[CTL_RATE_HI:CTL_RATE_LO] = ch_rate[i];
                        bus_rdata[CTL_PEND]                = ch_pend[i];
                    end
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk
    import timer_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_wr,
    input logic [ADDR_W-1:2]                bus_addr,
    input logic [DATA_W-1:0]                bus_wdata,
    input logic [N_TIMERS-1:0]              irq,
    input logic [N_TIMERS-1:0][DATA_W-1:0]  ch_count,
    input logic [N_TIMERS-1:0]              ch_run
);

    localparam int CH_W = ADDR_W - 4;

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
        logic mine, wr_cnt, wr_ctl, wr_clr;
        assign mine   = bus_wr && (bus_addr[ADDR_W-1:4] == CH_W'(i));
        assign wr_cnt = mine && (bus_addr[3:2] == REG_COUNT);
        assign wr_ctl = mine && (bus_addr[3:2] == REG_CTRL);
        assign wr_clr = wr_ctl && bus_wdata[CTL_PEND];

        // R3
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_run[i] && !wr_cnt |=> $stable(ch_count[i]));

        // R3
        step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_run[i] && (ch_count[i] > DATA_W'(1)) && !wr_cnt
            |=> (ch_count[i] == $past(ch_count[i])) ||
                (ch_count[i] == $past(ch_count[i]) - DATA_W'(1)));

        // R6
        irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> ($past(ch_count[i]) == DATA_W'(1)) && $past(ch_run[i]));

        // R7
        irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] && !wr_clr |=> irq[i]);

        // R5
        oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_run[i]) && !$past(wr_ctl) |-> (ch_count[i] == '0) && irq[i]);
    end

endmodule

bind dual_interval_timer dual_interval_timer_chk #(
    .N_TIMERS (N_TIMERS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .ch_count  (ch_count),
    .ch_run    (ch_run)
);

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/1ps
module dual_interval_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dual_interval_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[4:2]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a[4:2];
        #0.1;
        d = bus_rdata;
    endtask

    task automatic park(input logic [4:0] base);
        wr(base + 5'h08, 32'h10);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            chk("R1 register after reset", v, 32'h0);
        end
        chk("R1 irq after reset", {30'b0, irq}, 32'h0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr(5'h00, 32'hA5A5_1234);
        rd(5'h00, v); chk("R2 reload readback", v, 32'hA5A5_1234);
        wr(5'h08, 32'hFFFF_FFEE);
        rd(5'h08, v); chk("R2 control readback", v, 32'h0000_000E);
        rd(5'h0C, v); chk("R2 empty slot", v, 32'h0);
        wr(5'h08, 32'h0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(5'h04, 32'd5);
        wr(5'h08, 32'h1);
        rd(5'h04, v); chk("R3 count at arm", v, 32'd5);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            rd(5'h04, v); chk("R3 count per edge", v, 32'(5 - k));
            if (k == 4) chk("R5 irq before terminal", {31'b0, irq[0]}, 32'd0);
        end
        chk("R5 irq at terminal", {31'b0, irq[0]}, 32'd1);
        rd(5'h08, v); chk("R5 expired control", v, 32'h10);
        repeat (3) @(negedge clk);
        rd(5'h04, v); chk("R5 stays at zero", v, 32'd0);
        rd(5'h04, v);
        repeat (10) @(negedge clk);
        chk("R3 idle holds", bus_rdata, v);
        wr(5'h08, 32'h0);
        chk("R7 write without bit4 keeps irq", {31'b0, irq[0]}, 32'd1);
        park(5'h00);
        chk("R7 write-1 clears irq", {31'b0, irq[0]}, 32'd0);
    endtask

    task automatic t_rates;
        logic [31:0] c0, c1;
        for (int r = 1; r < 4; r++) begin
            wr(5'h04, 32'd1000);
            wr(5'h08, 32'(r << 2) | 32'h3);
            rd(5'h04, c0);
            repeat (64) @(negedge clk);
            rd(5'h04, c1);
            chk("R4 steps in 64 edges", c0 - c1, 32'(64 >> r));
            park(5'h00);
        end
    endtask

    task automatic t_autoreload;
        logic [31:0] v;
        wr(5'h00, 32'd3);
        wr(5'h04, 32'd2);
        wr(5'h08, 32'h3);
        @(negedge clk); rd(5'h04, v); chk("R6 count before terminal", v, 32'd1);
        chk("R6 irq low before terminal", {31'b0, irq[0]}, 32'd0);
        @(negedge clk); rd(5'h04, v); chk("R6 reload at terminal", v, 32'd3);
        chk("R6 irq at terminal", {31'b0, irq[0]}, 32'd1);
        repeat (3) @(negedge clk);
        rd(5'h04, v); chk("R6 keeps running", v, 32'd3);
        rd(5'h08, v); chk("R6 still enabled", v & 32'h1, 32'h1);
        wr(5'h04, 32'd100);
        rd(5'h04, v); chk("R8 direct load while running", v, 32'd100);
        @(negedge clk); rd(5'h04, v); chk("R8 continues from loaded value", v, 32'd99);
        park(5'h00);
    endtask

    task automatic t_zero_start;
        logic [31:0] v;
        wr(5'h00, 32'd4);
        wr(5'h04, 32'd0);
        wr(5'h08, 32'h3);
        @(negedge clk); rd(5'h04, v); chk("R10 zero loads reload", v, 32'd4);
        chk("R10 no irq on zero load", {31'b0, irq[0]}, 32'd0);
        repeat (4) @(negedge clk);
        rd(5'h04, v); chk("R10 reload after terminal", v, 32'd4);
        chk("R10 irq at later terminal", {31'b0, irq[0]}, 32'd1);
        park(5'h00);
    endtask

    task automatic t_independent;
        logic [31:0] v;
        wr(5'h00, 32'd77);
        wr(5'h04, 32'd9);
        wr(5'h10, 32'd7);
        wr(5'h14, 32'd50);
        wr(5'h18, 32'h0F);
        rd(5'h00, v); chk("R9 ch0 reload untouched", v, 32'd77);
        rd(5'h04, v); chk("R9 ch0 count untouched", v, 32'd9);
        rd(5'h18, v); chk("R9 ch1 control", v, 32'h0F);
        wr(5'h04, 32'd2);
        wr(5'h08, 32'h1);
        repeat (2) @(negedge clk);
        chk("R9 ch0 irq", {31'b0, irq[0]}, 32'd1);
        chk("R9 ch1 irq quiet", {31'b0, irq[1]}, 32'd0);
        rd(5'h18, v); chk("R9 ch1 still enabled", v, 32'h0F);
        rd(5'h10, v); chk("R9 ch1 reload untouched", v, 32'd7);
        park(5'h00);
        park(5'h10);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_oneshot();
        t_rates();
        t_autoreload();
        t_zero_start();
        t_independent();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule